// File: doc/BRIEF.md
# I2C Display Command/Data Parser

This block is the serial front end of a display controller. It listens on an I2C bus as a slave. It acknowledges its own 7-bit address and every byte written to it. It then sorts the incoming bytes into two kinds of output: controller commands, which leave on a byte output with a one-cycle valid strobe, and display RAM data, which leaves on a write port. The RAM write port carries an address taken from an internal pointer. That pointer advances after each write and returns to zero past a configurable top address.

Inside a write transfer, a control byte decides how the bytes after it are handled. Its most significant bit selects between two modes. In the first, one data byte follows and then another control byte. In the second, every byte is data until the transfer ends. The bit below it routes the data either to the command output or to RAM. A read transfer returns the status byte presented on an input, as long as the last control byte selected command routing.

SCL and SDA are oversampled by the system clock. SDA is driven open-drain through an output-enable.

Top module: `i2c_disp_parser`

## Requirements
- R1: While reset is high, and on the first clock after it, `cmd_valid`, `ram_we` and `sda_oe` are low.
- R2: The address byte is `0 1 1 1 1`, then `sa_sel[1]`, `sa_sel[0]`, then the direction bit (0 write, 1 read). It is sent MSB first. The slave acknowledges it only when all seven address bits match. On a mismatch it drives nothing and produces no output until the next START.
- R3: Once addressed for writing, the slave pulls SDA low during the ninth clock of every received byte, control or data.
- R4: When a control byte has bit 7 set, exactly one data byte follows. The byte after that is parsed as a new control byte.
- R5: When a control byte has bit 7 clear, every following byte is data until START or STOP.
- R6: Data bytes after a control byte with bit 6 clear appear on `cmd_data` with a one-cycle `cmd_valid`. With bit 6 set, they appear on `ram_data` with a one-cycle `ram_we`.
- R7: Each RAM write uses the current pointer as `ram_addr`, and the pointer then advances by one. After `MAX_ADDR` it wraps to 0. A `ptr_load` pulse loads `ptr_load_addr` into the pointer.
- R8: Bits 5 to 0 of a control byte have no effect.
- R9: In a read transfer, the slave drives one byte after each master acknowledge. The byte is `status_in` if the last control byte had bit 6 clear, and 0x00 if it had bit 6 set. A master not-acknowledge ends the read.
- R10: START, repeated START and STOP all return the parser to expecting a control byte, whatever mode it was in.
- R11: `cmd_valid` and `ram_we` are never high in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_o | output | 1 | Value driven on SDA when enabled (always 0) |
| sda_oe | output | 1 | Pulls SDA low when high |
| sa_sel | input | 2 | Configured low address bits |
| ptr_load | input | 1 | Loads the RAM pointer |
| ptr_load_addr | input | AW | Value for the RAM pointer |
| status_in | input | 8 | Status byte returned in read transfers |
| cmd_data | output | 8 | Decoded command byte |
| cmd_valid | output | 1 | One-cycle strobe for `cmd_data` |
| ram_addr | output | AW | Display RAM write address |
| ram_data | output | 8 | Display RAM write data |
| ram_we | output | 1 | One-cycle display RAM write strobe |

## Verification
The hardest state to reach from the ports is a parser left mid-mode when the frame ends. One case is a single-byte control that arrives with no data before STOP. Another is a command stream broken by a repeated START. The byte after either one must be taken as a control byte again. The bench builds these frames deliberately and then sends a control byte whose routing differs from the abandoned one, so a stale mode shows up as a wrongly routed byte. Pointer wrap is reached by loading the pointer just below `MAX_ADDR` and streaming across it. Reads are interleaved with writes of both routings, which checks which control byte the returned value follows.

// File: rtl/idp_pkg.sv
package idp_pkg;
  typedef enum logic [2:0] {
    BS_IDLE, BS_ADDR, BS_AACK, BS_WRX, BS_WACK, BS_RTX, BS_RACK
  } bus_st_t;

  typedef enum logic [1:0] {
    PS_CTRL, PS_ONE, PS_STREAM
  } parse_st_t;

  localparam logic [4:0] DEV_ID  = 5'b01111;
  localparam int         CO_BIT  = 7;
  localparam int         DC_BIT  = 6;
endpackage

// File: rtl/idp_line_sync.sv
module idp_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_pipe;
  logic [STAGES:0] sda_pipe;
  logic scl_now, scl_prev, sda_now, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  assign scl_now  = scl_pipe[STAGES-1];
  assign scl_prev = scl_pipe[STAGES];
  assign sda_now  = sda_pipe[STAGES-1];
  assign sda_prev = sda_pipe[STAGES];

  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/idp_bit_engine.sv
module idp_bit_engine
  import idp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] sa_sel,
  input  logic [7:0] tx_byte,
  output logic       sda_oe,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       frame_evt
);
  bus_st_t    state;
  logic [2:0] cnt;
  logic [7:0] rx_sr;
  logic [7:0] tx_sr;
  logic       full;
  logic       rw;
  logic       nack;

  always_ff @(posedge clk) begin
    rx_valid  <= 1'b0;
    frame_evt <= 1'b0;
    if (rst) begin
      state   <= BS_IDLE;
      cnt     <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      rx_data <= '0;
      full    <= 1'b0;
      rw      <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state     <= BS_ADDR;
      cnt       <= '0;
      full      <= 1'b0;
      sda_oe    <= 1'b0;
      frame_evt <= 1'b1;
    end else if (stop_det) begin
      state     <= BS_IDLE;
      full      <= 1'b0;
      sda_oe    <= 1'b0;
      frame_evt <= 1'b1;
    end else begin
      case (state)
        BS_ADDR, BS_WRX: begin
          if (scl_rise) begin
            rx_sr <= {rx_sr[6:0], sda_s};
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) full <= 1'b1;
          end else if (scl_fall && full) begin
            full <= 1'b0;
            if (state == BS_ADDR) begin
              if (rx_sr[7:3] == DEV_ID && rx_sr[2:1] == sa_sel) begin
                sda_oe <= 1'b1;
                rw     <= rx_sr[0];
                state  <= BS_AACK;
              end else begin
                state <= BS_IDLE;
              end
            end else begin
              sda_oe   <= 1'b1;
              rx_valid <= 1'b1;
              rx_data  <= rx_sr;
              state    <= BS_WACK;
            end
          end
        end
        BS_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx_sr  <= tx_byte;
              sda_oe <= ~tx_byte[7];
              state  <= BS_RTX;
            end else begin
              sda_oe <= 1'b0;
              state  <= BS_WRX;
            end
          end
        end
        BS_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= BS_WRX;
          end
        end
        BS_RTX: begin
          if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= BS_RACK;
            end else begin
              cnt    <= cnt + 3'd1;
              tx_sr  <= {tx_sr[6:0], 1'b0};
              sda_oe <= ~tx_sr[6];
            end
          end
        end
        BS_RACK: begin
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              state <= BS_IDLE;
            end else begin
              tx_sr  <= tx_byte;
              sda_oe <= ~tx_byte[7];
              cnt    <= '0;
              state  <= BS_RTX;
            end
          end
        end
        default: state <= BS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idp_cmd_router.sv
module idp_cmd_router
  import idp_pkg::*;
#(
  parameter int AW       = 10,
  parameter int MAX_ADDR = 815
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          frame_evt,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_load_addr,
  input  logic [7:0]    status_in,
  output logic [7:0]    tx_byte,
  output logic [7:0]    cmd_data,
  output logic          cmd_valid,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_data,
  output logic          ram_we
);
  localparam logic [AW-1:0] PTR_MAX = AW'(MAX_ADDR);

  parse_st_t     state;
  logic          dc;
  logic          last_dc;
  logic [AW-1:0] ptr;
  logic          data_byte;
  logic [AW-1:0] ptr_next;

  assign data_byte = rx_valid && !frame_evt && state != PS_CTRL;
  assign ptr_next  = (ptr == PTR_MAX) ? '0 : ptr + 1'b1;
  assign tx_byte   = last_dc ? 8'h00 : status_in;

  always_ff @(posedge clk) begin
    cmd_valid <= 1'b0;
    ram_we    <= 1'b0;
    if (rst) begin
      state    <= PS_CTRL;
      dc       <= 1'b0;
      last_dc  <= 1'b0;
      cmd_data <= '0;
      ram_addr <= '0;
      ram_data <= '0;
    end else if (frame_evt) begin
      state <= PS_CTRL;
    end else if (rx_valid) begin
      if (state == PS_CTRL) begin
        dc      <= rx_data[DC_BIT];
        last_dc <= rx_data[DC_BIT];
        state   <= rx_data[CO_BIT] ? PS_ONE : PS_STREAM;
      end else begin
        if (dc) begin
          ram_we   <= 1'b1;
          ram_addr <= ptr;
          ram_data <= rx_data;
        end else begin
          cmd_valid <= 1'b1;
          cmd_data  <= rx_data;
        end
        if (state == PS_ONE) state <= PS_CTRL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   ptr <= '0;
    else if (ptr_load)         ptr <= ptr_load_addr;
    else if (data_byte && dc)  ptr <= ptr_next;
  end
endmodule

// File: rtl/i2c_disp_parser.sv
module i2c_disp_parser #(
  parameter int AW          = 10,
  parameter int MAX_ADDR    = 815,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_o,
  output logic          sda_oe,
  input  logic [1:0]    sa_sel,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_load_addr,
  input  logic [7:0]    status_in,
  output logic [7:0]    cmd_data,
  output logic          cmd_valid,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_data,
  output logic          ram_we
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       rx_valid, frame_evt;
  logic [7:0] rx_data, tx_byte;

  assign sda_o = 1'b0;

  idp_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  idp_bit_engine engine_i (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sa_sel(sa_sel), .tx_byte(tx_byte), .sda_oe(sda_oe),
    .rx_valid(rx_valid), .rx_data(rx_data), .frame_evt(frame_evt)
  );

  idp_cmd_router #(.AW(AW), .MAX_ADDR(MAX_ADDR)) router_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .frame_evt(frame_evt), .ptr_load(ptr_load),
    .ptr_load_addr(ptr_load_addr), .status_in(status_in),
    .tx_byte(tx_byte), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .ram_addr(ram_addr), .ram_data(ram_data), .ram_we(ram_we)
  );
endmodule

// File: rtl/idp_checker.sv
module idp_checker #(
  parameter int AW       = 10,
  parameter int MAX_ADDR = 815
) (
  input logic          clk,
  input logic          rst,
  input logic          sda_oe,
  input logic          ptr_load,
  input logic [AW-1:0] ptr_load_addr,
  input logic          cmd_valid,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr
);
  localparam logic [AW-1:0] PTR_MAX = AW'(MAX_ADDR);

  logic          ld_d;
  logic [AW-1:0] ld_addr_d;
  logic [AW-1:0] nxt;
  logic          nxt_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_d      <= 1'b0;
      ld_addr_d <= '0;
      nxt       <= '0;
      nxt_ok    <= 1'b1;
    end else begin
      ld_d      <= ptr_load;
      ld_addr_d <= ptr_load_addr;
      if (ld_d) begin
        nxt    <= ld_addr_d;
        nxt_ok <= 1'b1;
      end else if (ram_we) begin
        nxt <= (ram_addr == PTR_MAX) ? '0 : ram_addr + 1'b1;
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!cmd_valid && !ram_we && !sda_oe));

  a_r11_exclusive_strobes: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && ram_we));

  a_r11_cmd_single: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  a_r11_ram_single: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);

  a_r7_ptr_sequence: assert property (@(posedge clk) disable iff (rst)
    (ram_we && nxt_ok) |-> (ram_addr == nxt));
endmodule

bind i2c_disp_parser idp_checker #(.AW(AW), .MAX_ADDR(MAX_ADDR)) chk_i (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .ptr_load(ptr_load),
  .ptr_load_addr(ptr_load_addr), .cmd_valid(cmd_valid),
  .ram_we(ram_we), .ram_addr(ram_addr)
);

// File: tb/i2c_disp_parser_tb_top.sv
`timescale 1ns/1ps
module i2c_disp_parser_tb_top;
  localparam int AW   = 10;
  localparam int MAXA = 815;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_o, sda_oe;
  logic sda_line;
  logic [1:0] sa_sel = 2'b10;
  logic ptr_load = 1'b0;
  logic [AW-1:0] ptr_load_addr = '0;
  logic [7:0] status_in = 8'hA5;
  logic [7:0] cmd_data, ram_data;
  logic cmd_valid, ram_we;
  logic [AW-1:0] ram_addr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  int exp_cmd[$];
  int exp_ram[$];
  int mst = 0;
  int mdc = 0;
  int mlast = 0;
  int mptr = 0;
  logic [7:0] pay[$];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_disp_parser #(.AW(AW), .MAX_ADDR(MAXA)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .sa_sel(sa_sel),
    .ptr_load(ptr_load), .ptr_load_addr(ptr_load_addr),
    .status_in(status_in), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .ram_addr(ram_addr), .ram_data(ram_data), .ram_we(ram_we)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Reference model compared on every clock: each strobe must match the next queued expectation
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid) begin
        if (exp_cmd.size() == 0) check(0, "R6 unexpected cmd", cmd_data, -1);
        else check(cmd_data == exp_cmd.pop_front(), "R6 cmd byte", cmd_data, cmd_data ^ 1);
      end
      if (ram_we) begin
        if (exp_ram.size() == 0) check(0, "R6 unexpected ram write", {ram_addr, ram_data}, -1);
        else begin
          int e;
          e = exp_ram.pop_front();
          check({ram_addr, ram_data} == e, "R7 ram addr/data", {ram_addr, ram_data}, e);
        end
      end
      if (cmd_valid && ram_we) check(0, "R11 both strobes", 3, 0);
    end
  end

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_byte(input logic [7:0] b);
    if (mst == 0) begin
      mdc = b[6]; mlast = b[6];
      mst = b[7] ? 1 : 2;
    end else begin
      if (mdc != 0) begin
        exp_ram.push_back((mptr << 8) | b);
        mptr = (mptr == MAXA) ? 0 : mptr + 1;
      end else exp_cmd.push_back(b);
      if (mst == 1) mst = 0;
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
    mst = 0;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
    mst = 0;
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(Q);
      scl_m = 1'b1; wait_q(2 * Q);
      scl_m = 1'b0; wait_q(Q);
    end
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    ack = ~sda_line; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q(Q);
      scl_m = 1'b1; wait_q(Q);
      b[i] = sda_line; wait_q(Q);
      scl_m = 1'b0;
    end
    wait_q(Q);
    sda_m = ~give_ack; wait_q(Q);
    scl_m = 1'b1; wait_q(2 * Q);
    scl_m = 1'b0; wait_q(Q);
    sda_m = 1'b1;
  endtask

  // Write frame: address, then every byte of pay; stop unless keep_open
  task automatic wr_frame(input logic [1:0] sa, input bit keep_open, input string req);
    bit ack;
    bus_start();
    write_byte({5'b01111, sa, 1'b0}, ack);
    check(ack == 1'b1, "R2 address ack", ack, 1);
    foreach (pay[k]) begin
      model_byte(pay[k]);
      write_byte(pay[k], ack);
      check(ack == 1'b1, req, ack, 1);
    end
    if (!keep_open) bus_stop();
  endtask

  task automatic drain(input string req);
    wait_q(20);
    check(exp_cmd.size() == 0 && exp_ram.size() == 0, req,
          exp_cmd.size() + exp_ram.size(), 0);
  endtask

  task automatic load_ptr(input int a);
    ptr_load_addr = AW'(a); ptr_load = 1'b1;
    wait_q(1);
    ptr_load = 1'b0;
    mptr = a;
  endtask

  task automatic rd_frame(input int nbytes, input string req);
    bit ack;
    logic [7:0] b;
    int expv;
    bus_start();
    write_byte({5'b01111, sa_sel, 1'b1}, ack);
    check(ack == 1'b1, "R2 read address ack", ack, 1);
    expv = (mlast != 0) ? 0 : status_in;
    for (int n = 0; n < nbytes; n++) begin
      read_byte(n != nbytes - 1, b);
      check(b == expv[7:0], req, b, expv);
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    wait_q(5);
    check(!cmd_valid && !ram_we && !sda_oe, "R1 outputs during reset",
          {cmd_valid, ram_we, sda_oe}, 0);
    rst = 1'b0;
    wait_q(1);
    check(!cmd_valid && !ram_we && !sda_oe, "R1 outputs after reset",
          {cmd_valid, ram_we, sda_oe}, 0);
    wait_q(5);

    // R2: wrong select bits, no ack and no output for later bytes
    bus_start();
    write_byte({5'b01111, 2'b01, 1'b0}, ack);
    check(ack == 1'b0, "R2 mismatched address not acked", ack, 0);
    write_byte(8'h80, ack);
    check(ack == 1'b0, "R2 ignored after mismatch", ack, 0);
    write_byte(8'h55, ack);
    bus_stop();
    drain("R2 no output after mismatch");

    // R4 R6 R3: single-byte command words
    pay = '{8'h80, 8'h21, 8'h80, 8'h14};
    wr_frame(sa_sel, 0, "R3 ack command word byte");
    drain("R4 command words delivered");

    // R8: stray low bits in control bytes
    pay = '{8'hBF, 8'h3C, 8'hFF, 8'h5A};
    wr_frame(sa_sel, 0, "R8 ack with stray control bits");
    drain("R8 low control bits ignored");

    // R5 R6 R7: ram single then stream from loaded pointer
    load_ptr(40);
    pay = '{8'hC0, 8'h11, 8'h40, 8'h22, 8'h33, 8'hC0, 8'h44};
    wr_frame(sa_sel, 0, "R5 ack stream byte");
    drain("R5 stream to RAM");

    // R9: last routing was RAM, read returns zero
    rd_frame(2, "R9 read after RAM routing");

    // R7: wrap across the top address
    load_ptr(MAXA - 1);
    pay = '{8'h40, 8'hA1, 8'hA2, 8'hA3};
    wr_frame(sa_sel, 0, "R7 ack wrap stream");
    drain("R7 pointer wrap");

    // R5: command stream
    pay = '{8'h00, 8'h01, 8'h02, 8'h03};
    wr_frame(sa_sel, 0, "R5 ack command stream");
    drain("R5 command stream");

    // R9: last routing was command, read returns status twice
    status_in = 8'h6C;
    rd_frame(2, "R9 status read");

    // R10: stream broken by repeated START
    pay = '{8'h00, 8'h77};
    wr_frame(sa_sel, 1, "R10 ack before restart");
    pay = '{8'hC0, 8'h99};
    wr_frame(sa_sel, 0, "R10 ack after restart");
    drain("R10 repeated start resets parser");

    // R10: single-mode control then STOP with no data
    pay = '{8'h80};
    wr_frame(sa_sel, 0, "R10 ack lone control");
    pay = '{8'hC0, 8'h5E};
    wr_frame(sa_sel, 0, "R10 ack after stop");
    drain("R10 stop resets parser");

    // R2: other select value matches after reconfiguration
    sa_sel = 2'b01;
    pay = '{8'h80, 8'hE7};
    wr_frame(2'b01, 0, "R2 ack new select");
    drain("R2 new select accepted");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule